// File: doc/BRIEF.md
# Registered ROM with Initialize Word

The block is a 2048 x 8 read-only store whose read data passes through an edge-triggered output register. At each rising clock edge the word at the current address is captured into the register and shown on the data outputs. Address and enable inputs may change freely between edges without disturbing what is already on the outputs.

A spare initialize word can be forced into the output register at any time by holding an active-low initialize input low. This load is level-sensitive and does not wait for the clock. The output enable works in one of two modes chosen by a control byte. In the immediate mode the enable input acts combinationally. In the clocked mode the enable is sampled on rising edges. High impedance is shown as an output-valid flag that drops while the data bus reads zero.

The array, the initialize word and the control byte are all loaded through a configuration write port. That port only accepts writes while reset is held, which models the programming step that comes before use.

Top module: `init_reg_rom`

## Requirements
- R1: A configuration write to addresses 0x000 to 0x7FF stores the byte in the array word of that index, and a later read of that index returns it.
- R2: The register captures the array word at the address present at a rising edge, and the outputs show it from that edge on. Address changes between edges leave the outputs unchanged.
- R3: While `init_n` is low, the register holds the initialize word immediately, without a clock edge and regardless of the address and enable inputs.
- R4: A rising edge that arrives while `init_n` is low keeps the initialize word. The first rising edge after `init_n` returns high loads the array word again.
- R5: If address 0x800 is never written, the initialize word is 0x00 and `init_n` clears the outputs. When it is written with 0xFF, `init_n` presets them.
- R6: Configuration address 0x800 holds the initialize word and 0x801 holds the control byte. Control bit 0 set selects clocked enable and clear selects immediate enable, which is the default. The other control bits have no effect.
- R7: In immediate mode, `dout_oe` equals the inverse of `en_n` in the same cycle, with no clock edge needed.
- R8: In clocked mode, `en_n` is sampled at each rising edge. `dout_oe` takes the inverse of the sampled value at that edge and holds it until the next edge.
- R9: While `rst_n` is low, the register is set to 0xFF (unless `init_n` is low). In clocked mode the outputs are off. In immediate mode the outputs are off only while `en_n` is high.
- R10: Configuration writes made while `rst_n` is high change nothing. Writes to addresses above 0x801 change nothing at any time.
- R11: Whenever `dout_oe` is low, `dout` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; rising edge loads the output register |
| rst_n | input | 1 | Active-low reset; configuration window |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 12 | Configuration address (array, 0x800 initialize word, 0x801 control) |
| cfg_data | input | 8 | Configuration write data |
| addr | input | 11 | Read address |
| init_n | input | 1 | Active-low level-sensitive initialize |
| en_n | input | 1 | Active-low output enable |
| dout | output | 8 | Registered read data, zero when disabled |
| dout_oe | output | 1 | Output-valid flag standing for driven outputs |

## Verification
Array reads and clocked-mode enable changes are due one rising edge after the inputs are sampled. The bench drives inputs at the falling edge and updates its model at the next rising edge. It then compares at the following falling edge, just after the next stimulus is applied. Initialize and immediate-mode enable effects are due in the same cycle with no edge. The bench therefore checks them 1 ns after driving, before any rising edge, so these checks also confirm that no clock was needed.

// File: rtl/init_reg_rom.sv
module init_reg_rom #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [AW:0]   cfg_addr,
  input  logic [DW-1:0] cfg_data,
  input  logic [AW-1:0] addr,
  input  logic          init_n,
  input  logic          en_n,
  output logic [DW-1:0] dout,
  output logic          dout_oe
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW:0] INIT_LOC = (AW+1)'(DEPTH);
  localparam logic [AW:0] CTRL_LOC = (AW+1)'(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] init_word = '0;
  logic [DW-1:0] ctrl_q = '0;
  logic [DW-1:0] data_q;
  logic          oe_q;
  logic          cfg_ok;
  logic          sync_mode;

  assign cfg_ok    = !rst_n && cfg_we;
  assign sync_mode = ctrl_q[0];

  always_ff @(posedge clk) begin
    if (cfg_ok && !cfg_addr[AW]) mem[cfg_addr[AW-1:0]] <= cfg_data;
    if (cfg_ok && cfg_addr == INIT_LOC) init_word <= cfg_data;
    if (cfg_ok && cfg_addr == CTRL_LOC) ctrl_q <= cfg_data;
  end

  always_ff @(posedge clk or negedge rst_n or negedge init_n) begin
    if (!init_n)     data_q <= init_word;
    else if (!rst_n) data_q <= '1;
    else             data_q <= mem[addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) oe_q <= 1'b0;
    else        oe_q <= !en_n;
  end

  assign dout_oe = sync_mode ? oe_q : !en_n;
  assign dout    = dout_oe ? data_q : '0;

  a_r8_sync_oe: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_mode && $past(rst_n)) |-> (dout_oe == !$past(en_n)));

  a_r4_init_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !init_n |-> (data_q == init_word));

  a_r10_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ($stable(init_word) && $stable(ctrl_q)));

  a_r9_reset_off: assert property (@(posedge clk)
    (!rst_n && $past(!rst_n) && sync_mode) |-> !dout_oe);
endmodule

// File: tb/init_reg_rom_tb.sv
module init_reg_rom_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [11:0] cfg_addr = '0;
  logic [7:0]  cfg_data = '0;
  logic [10:0] addr = '0;
  logic        init_n = 1'b1;
  logic        en_n = 1'b1;
  logic [7:0]  dout;
  logic        dout_oe;

  int total = 0;
  int bad = 0;
  logic [7:0] m [2048];
  logic [7:0] iw = 8'h00;
  logic [7:0] mq = 8'hFF;
  logic       moe = 1'b0;
  logic       sync = 1'b0;

  always #4 clk = ~clk;

  init_reg_rom dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_data(cfg_data), .addr(addr), .init_n(init_n), .en_n(en_n),
    .dout(dout), .dout_oe(dout_oe)
  );

  task automatic chk(string tg, logic [7:0] got, logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tg, got, exp);
    end
  endtask

  function automatic logic exp_oe(logic e);
    return sync ? moe : !e;
  endfunction

  task automatic cfg_wr(logic [11:0] a, logic [7:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cyc(logic [10:0] a, logic e, logic i, string tg = "",
                     logic we = 1'b0, logic [11:0] ca = '0, logic [7:0] cd = '0);
    logic eo;
    addr = a; en_n = e; init_n = i; cfg_we = we; cfg_addr = ca; cfg_data = cd;
    #1;
    if (!i) mq = iw;
    eo = exp_oe(e);
    chk(sync ? "R8" : "R7", {7'b0, dout_oe}, {7'b0, eo});
    chk(tg != "" ? tg : (!eo ? "R11" : (!i ? "R3" : "R2")), dout, eo ? mq : 8'h00);
    @(posedge clk);
    mq = i ? m[a] : iw;
    if (sync) moe = !e;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_reset(logic [7:0] niw, logic [7:0] nctl);
    rst_n = 1'b0; init_n = 1'b1; en_n = 1'b1;
    #1;
    chk("R9", {7'b0, dout_oe}, 8'h00);
    chk("R11", dout, 8'h00);
    @(negedge clk);
    cfg_wr(12'h800, niw);
    cfg_wr(12'h801, nctl);
    cfg_wr(12'h802, ~nctl);
    cfg_wr(12'hC05, ~m[12'h405]);
    iw = niw; sync = nctl[0];
    en_n = 1'b0;
    #1;
    chk("R9", {7'b0, dout_oe}, sync ? 8'h00 : 8'h01);
    chk("R9", dout, sync ? 8'h00 : 8'hFF);
    @(negedge clk);
    rst_n = 1'b1; mq = 8'hFF; moe = 1'b0;
  endtask

  task automatic rnd(int n);
    for (int k = 0; k < n; k++)
      cyc(11'($urandom), ($urandom % 4) == 0, ($urandom % 8) != 0);
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    $display("FAIL watchdog");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (2) @(negedge clk);
    #1;
    chk("R9", {7'b0, dout_oe}, 8'h00);
    en_n = 1'b0;
    #1;
    chk("R6", {7'b0, dout_oe}, 8'h01);
    chk("R9", dout, 8'hFF);
    en_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 2048; i++) begin
      m[i] = 8'($urandom);
      if (i == 12'h100) m[i] = 8'hA5;
      cfg_wr(12'(i), m[i]);
    end
    cfg_wr(12'h900, 8'h5A);
    cfg_wr(12'h802, 8'h01);
    @(negedge clk);
    rst_n = 1'b1; mq = 8'hFF; moe = 1'b0;

    cyc(11'h123, 1'b0, 1'b1);
    cyc(11'h456, 1'b0, 1'b1, "R1");
    cyc(11'h7FF, 1'b0, 1'b1, "R2");
    cyc(11'h000, 1'b1, 1'b1, "R11");
    cyc(11'h000, 1'b1, 1'b0, "R7");
    cyc(11'h000, 1'b0, 1'b0, "R5");
    cyc(11'h200, 1'b0, 1'b0, "R4");
    cyc(11'h100, 1'b0, 1'b0, "R4");
    cyc(11'h100, 1'b0, 1'b1, "R4");
    cyc(11'h300, 1'b0, 1'b1, "R10");
    cyc(11'h300, 1'b0, 1'b1, "R6");
    rnd(300);

    do_reset(8'hFF, 8'h00);
    cyc(11'h405, 1'b0, 1'b1);
    cyc(11'h0AB, 1'b0, 1'b1, "R10");
    cyc(11'h0AB, 1'b1, 1'b0, "R11");
    cyc(11'h0AB, 1'b0, 1'b0, "R5");
    rnd(200);

    do_reset(8'($urandom), 8'hFD);
    cyc(11'h010, 1'b0, 1'b1, "R9");
    cyc(11'h020, 1'b1, 1'b1, "R8");
    cyc(11'h030, 1'b0, 1'b1, "R8");
    cyc(11'h040, 1'b0, 1'b1, "R6");
    cyc(11'h005, 1'b0, 1'b1, "", 1'b1, 12'h800, ~iw);
    cyc(11'h005, 1'b0, 1'b1, "", 1'b1, 12'h801, 8'h00);
    cyc(11'h005, 1'b0, 1'b1, "", 1'b1, 12'h005, ~m[5]);
    cyc(11'h005, 1'b0, 1'b0, "R10");
    cyc(11'h005, 1'b0, 1'b1, "R4");
    cyc(11'h006, 1'b1, 1'b1, "R10");
    cyc(11'h006, 1'b0, 1'b1, "R8");
    rnd(300);

    do_reset(8'h3C, 8'h02);
    cyc(11'h055, 1'b0, 1'b1, "R6");
    cyc(11'h055, 1'b0, 1'b0, "R3");
    rnd(200);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule